// File: doc/BRIEF.md
# Flash Program Command Sequencer

This block sits between a host request port and a parallel NOR flash bus running in 16-bit word mode. A single host request to program one word becomes the four bus writes the flash expects before it accepts data: two unlock writes, a program command write, and finally the write of the user's data to the user's address. Plain read requests go straight onto the bus as a single read cycle, with no command cycles ahead of them.

The host can only reach the upper half of the flash address space. The flash decodes only the low fifteen address bits during command cycles, so the sequencer adds a fixed offset to the unlock and command addresses. This moves them into the visible window while the flash still sees the codes it needs. The final data write uses the user address as given, and that address must already lie inside the window. The block drives chip enable, write enable and output enable with fixed setup and hold around every write pulse. The caller must erase the target block beforehand; the sequencer only programs.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is held, chip enable, write enable and output enable are all high (inactive), busy is low, the data bus driver is off and read-valid is low.
- R2: A write request whose address is in the window produces exactly four write-enable pulses. Their address/data pairs are (0xD555, 0x00AA), (0xAAAA, 0x0055), (0xD555, 0x00A0) and then (user address, user data), in that order.
- R3: Every address presented during a write-enable pulse is at or above 0x8000. The command addresses are 0x5555 and 0x2AAA plus the offset 0x8000.
- R4: A write request with an address below 0x8000 gives a one-clock error pulse in the clock after it is accepted. It causes no write-enable pulse and leaves busy low.
- R5: Each write-enable pulse is low for exactly WE_PULSE clocks, and chip enable is low throughout it.
- R6: Address and write data hold the same values for one clock before write enable falls and for one clock after it rises, with chip enable still low in both of those clocks.
- R7: Output enable stays high whenever the data bus is driven and during every write-enable pulse.
- R8: A read request gives one setup clock followed by RD_WAIT clocks with output enable low at the request address. The data on the bus in the last of those clocks is returned on the read-data output with a one-clock read-valid pulse, and no write pulse occurs. Reads are not window-checked.
- R9: Busy is high for exactly 4*(WE_PULSE+2) clocks for a write and RD_WAIT+1 clocks for a read, starting in the clock after acceptance. Requests presented while busy is high are ignored.
- R10: The byte-select output is held high (16-bit mode) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = program word, 0 = read |
| req_addr | input | AW | Flash word address |
| req_wdata | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| err | output | 1 | One-clock pulse: write address outside window |
| rd_valid | output | 1 | One-clock pulse: rd_data valid |
| rd_data | output | DW | Captured read word |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Flash data bus, outgoing |
| fl_dq_oe | output | 1 | Enable for the outgoing data driver |
| fl_dq_in | input | DW | Flash data bus, incoming |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_byte_n | output | 1 | Byte-select, tied high for word mode |

## Verification
The bench builds the sequencer with WE_PULSE=3 and RD_WAIT=2, so the pulse width and the read wait differ from the defaults and from each other. An off-by-one in either counter, or a mix-up between the two, therefore changes the pulse widths and busy lengths that the bench measures. With a three-clock pulse the bench can also check that the bus stays stable in the middle of a pulse, not only at its edges. The default window and offset are kept so that the command addresses land on 0xD555 and 0xAAAA, next to window edges at 0x7FFF/0x8000 and 0xFFFF.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WE_PULSE = 2,
  parameter int RD_WAIT = 3,
  parameter logic [AW-1:0] CMD_OFS = 'h8000,
  parameter logic [AW-1:0] WIN_BASE = 'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          err,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dout,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_byte_n
);
  localparam int MAXC = (WE_PULSE > RD_WAIT) ? WE_PULSE : RD_WAIT;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [AW-1:0] UNLOCK_A = AW'('h5555) + CMD_OFS;
  localparam logic [AW-1:0] UNLOCK_B = AW'('h2AAA) + CMD_OFS;

  typedef enum logic [2:0] {S_IDLE, S_SET, S_WE, S_HOLD, S_RSET, S_ROE} st_t;
  st_t st;
  logic [1:0]    step;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ua;
  logic [DW-1:0] ud;

  function automatic logic [AW-1:0] cyc_addr(input logic [1:0] s, input logic [AW-1:0] u);
    case (s)
      2'd1:    cyc_addr = UNLOCK_B;
      2'd3:    cyc_addr = u;
      default: cyc_addr = UNLOCK_A;
    endcase
  endfunction

  function automatic logic [DW-1:0] cyc_data(input logic [1:0] s, input logic [DW-1:0] u);
    case (s)
      2'd0:    cyc_data = DW'('h00AA);
      2'd1:    cyc_data = DW'('h0055);
      2'd2:    cyc_data = DW'('h00A0);
      default: cyc_data = u;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; cnt <= '0; ua <= '0; ud <= '0;
      fl_addr <= '0; fl_dout <= '0; err <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      err <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (!req_write) begin
            fl_addr <= req_addr;
            st <= S_RSET;
          end else if (req_addr >= WIN_BASE) begin
            ua <= req_addr; ud <= req_wdata; step <= 2'd0;
            fl_addr <= UNLOCK_A; fl_dout <= DW'('h00AA);
            st <= S_SET;
          end else begin
            err <= 1'b1;
          end
        end
        S_SET: begin cnt <= CW'(WE_PULSE - 1); st <= S_WE; end
        S_WE: if (cnt == '0) st <= S_HOLD; else cnt <= cnt - 1'b1;
        S_HOLD: if (step == 2'd3) st <= S_IDLE;
          else begin
            step <= step + 2'd1;
            fl_addr <= cyc_addr(step + 2'd1, ua);
            fl_dout <= cyc_data(step + 2'd1, ud);
            st <= S_SET;
          end
        S_RSET: begin cnt <= CW'(RD_WAIT - 1); st <= S_ROE; end
        S_ROE: if (cnt == '0) begin
            rd_data <= fl_dq_in; rd_valid <= 1'b1; st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign fl_ce_n   = (st == S_IDLE);
  assign fl_we_n   = (st != S_WE);
  assign fl_oe_n   = (st != S_ROE);
  assign fl_dq_oe  = (st == S_SET) || (st == S_WE) || (st == S_HOLD);
  assign fl_byte_n = 1'b1;

  assert_setup_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> $stable(fl_addr) && $stable(fl_dout) && $past(!fl_ce_n));
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> $stable(fl_addr) && $stable(fl_dout) && !fl_ce_n);
  assert_oe_off_when_driving_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_dq_oe || !fl_we_n) |-> fl_oe_n);
  assert_write_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_addr >= WIN_BASE);
  assert_err_only_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && $past(!busy));
  assert_read_after_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!fl_oe_n) && fl_we_n);
  assert_ce_with_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n && busy);
endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
  localparam int WEP = 3;
  localparam int RDW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic busy, err, rd_valid, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, fl_byte_n;
  logic [15:0] rd_data, fl_addr, fl_dout, fl_dq_in;

  int checks = 0, bad = 0, mchecks = 0, mbad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign fl_dq_in = fl_oe_n ? 16'h0000 : (fl_addr ^ 16'h5A5A);

  flash_prog_seq #(.AW(16), .DW(16), .WE_PULSE(WEP), .RD_WAIT(RDW)) i_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .err(err),
    .rd_valid(rd_valid), .rd_data(rd_data), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_byte_n(fl_byte_n));

  logic [15:0] pa [64];
  logic [15:0] pd [64];
  int npulse = 0, run = 0;
  logic pwe = 1'b1, pce = 1'b1;
  logic [15:0] la = '0, ld = '0;

  task automatic mchk(input bit ok, input string tag, input int act, input int exp);
    mchecks++;
    if (!ok) begin
      mbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n) begin
      mchk(fl_oe_n && !fl_ce_n, "R7/R5 oe high, ce low in pulse", {fl_oe_n, fl_ce_n}, 2);
      if (pwe) begin
        mchk(la == fl_addr && ld == fl_dout && !pce, "R6 setup stable", int'(la), int'(fl_addr));
        if (npulse < 64) begin pa[npulse] = fl_addr; pd[npulse] = fl_dout; end
        run = 1;
      end else begin
        run++;
        mchk(la == fl_addr && ld == fl_dout, "R6 stable within pulse", int'(fl_addr), int'(la));
      end
    end else if (!pwe) begin
      mchk(run == WEP, "R5 pulse width", run, WEP);
      mchk(fl_addr == la && fl_dout == ld && !fl_ce_n, "R6 hold stable", int'(fl_addr), int'(la));
      npulse++;
    end
    if (fl_dq_oe) mchk(fl_oe_n, "R7 oe while driving", fl_oe_n, 1);
    pwe = fl_we_n; pce = fl_ce_n; la = fl_addr; ld = fl_dout;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_a(input int k, input logic [15:0] u);
    case (k)
      0, 2: exp_a = 16'hD555;
      1: exp_a = 16'hAAAA;
      default: exp_a = u;
    endcase
  endfunction

  function automatic logic [15:0] exp_d(input int k, input logic [15:0] u);
    case (k)
      0: exp_d = 16'h00AA;
      1: exp_d = 16'h0055;
      2: exp_d = 16'h00A0;
      default: exp_d = u;
    endcase
  endfunction

  // {write, addr, data, out_of_window}
  localparam logic [33:0] VEC [8] = '{
    {1'b1, 16'h8000, 16'h1234, 1'b0},
    {1'b1, 16'hFFFF, 16'hABCD, 1'b0},
    {1'b1, 16'h7FFF, 16'h1111, 1'b1},
    {1'b0, 16'h9000, 16'h0000, 1'b0},
    {1'b1, 16'hC3A5, 16'h0000, 1'b0},
    {1'b0, 16'h0123, 16'h0000, 1'b0},
    {1'b1, 16'h0000, 16'hFFFF, 1'b1},
    {1'b0, 16'hFFFF, 16'h0000, 1'b0}
  };

  task automatic run_req(input bit wr, input logic [15:0] a, input logic [15:0] d, input bit oob);
    int start;
    int n;
    int expn;
    start = npulse;
    n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (oob) begin
      chk(err == 1'b1, "R4 err pulse", err, 1);
      chk(busy == 1'b0, "R4 busy stays low", busy, 0);
      repeat (6) @(negedge clk);
      chk(npulse == start, "R4 no write pulse", npulse - start, 0);
    end else begin
      chk(err == 1'b0, "R4 no err in window", err, 0);
      while (busy && n < 200) begin n++; @(negedge clk); end
      expn = wr ? 4 * (WEP + 2) : RDW + 1;
      chk(n == expn, "R9 busy length", n, expn);
      if (wr) begin
        chk(npulse == start + 4, "R2 four pulses", npulse - start, 4);
        for (int k = 0; k < 4; k++) begin
          chk(pa[start + k] == exp_a(k, a), "R2/R3 pulse address", int'(pa[start + k]), int'(exp_a(k, a)));
          chk(pd[start + k] == exp_d(k, d), "R2 pulse data", int'(pd[start + k]), int'(exp_d(k, d)));
        end
      end else begin
        chk(rd_valid == 1'b1, "R8 read valid", rd_valid, 1);
        chk(rd_data == (a ^ 16'h5A5A), "R8 read data", int'(rd_data), int'(a ^ 16'h5A5A));
        chk(npulse == start, "R8 no write on read", npulse - start, 0);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R8 read valid one clock", rd_valid, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes inactive", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    chk(!busy && !fl_dq_oe && !rd_valid && !err, "R1 idle outputs", {busy, fl_dq_oe, rd_valid, err}, 0);
    chk(fl_byte_n == 1'b1, "R10 byte select in reset", fl_byte_n, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++)
      run_req(VEC[i][33], VEC[i][32:17], VEC[i][16:1], VEC[i][0]);

    begin : busy_ignore
      int start;
      int n;
      start = npulse;
      n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hA000; req_wdata = 16'h4242;
      @(negedge clk);
      req_addr = 16'hB000; req_wdata = 16'h9999;
      repeat (2) @(negedge clk);
      req_write = 1'b0;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      while (busy && n < 200) begin n++; @(negedge clk); end
      chk(n == 4 * (WEP + 2) - 4, "R9 busy while requests ignored", n, 4 * (WEP + 2) - 4);
      chk(npulse == start + 4, "R9 only one sequence", npulse - start, 4);
      chk(pa[start + 3] == 16'hA000 && pd[start + 3] == 16'h4242, "R9 first request kept",
          int'(pa[start + 3]), 16'hA000);
      repeat (10) @(negedge clk);
      chk(!busy && npulse == start + 4 && !rd_valid, "R9 no late start", npulse - start, 4);
    end

    chk(fl_byte_n == 1'b1, "R10 byte select", fl_byte_n, 1);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks + mchecks, bad + mbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks + mchecks + 1, bad + mbad);
      $finish;
    end
  end
endmodule